// File: doc/BRIEF.md
# Power-gated banked DRAM controller

This block runs a small dynamic RAM array of up to four banks. Each bank stores 1K words of 4 bits, made of four 1K x 1 devices that share one 5-bit row address and one 5-bit column address. Every bank has its own supply-enable output. A bank is powered only while it is being refreshed or accessed, and sits in a low-power retention state the rest of the time. Whenever a supply is switched on, the controller waits a fixed number of clocks before it drives any strobe to that bank.

Each machine-cycle start pulse triggers a refresh pass. The pass powers every populated bank, waits for the supplies to settle, and then walks the row address from the top row down to row 0. After the pass, one pending CPU access is served. The CPU side is a plain request/acknowledge pair with a 12-bit word address and 4-bit data. A request that arrives during a pass is held until the pass ends. If machine-cycle starts stop arriving, an internal timer starts a pass by itself, so the refresh interval stays bounded.

Top module: `pgdram_ctrl`

## Requirements
- R1: The word address is decoded as bank = req_addr[11:10], row = req_addr[9:5], column = req_addr[4:0]. A write followed by a read of the same address returns the written value, and a data access raises col_stb only together with row_stb of the same bank.
- R2: A request whose bank field is NUM_BANKS or higher is acknowledged with rd_data = 4'h0. It drives no strobe and no supply enable, and it leaves all stored data unchanged.
- R3: For every bank, bank_pwr has been high for at least SETTLE_CLKS clocks before any cycle in which that bank's row_stb is high.
- R4: A pass drives row_stb of all populated banks together, with col_stb low and mem_we low. It holds each row for exactly 2 clocks, visits rows 31, 30, ..., 0 in that order, and makes 64 strobe cycles in all.
- R5: A request made while a pass is running gets no data strobe until the pass has finished, and it is served right after the pass.
- R6: ack is high for exactly one clock per request. In an idle controller, the ack for a populated bank appears SETTLE_CLKS+4 clock edges after the request is driven, and for an unpopulated bank 2 edges after.
- R7: All bank_pwr bits are low in the cycle that follows the end of a pass when no request is pending, and in the cycle in which ack is high.
- R8: When no cycle_start arrives and no access is running, passes start exactly TIMEOUT_CLKS clocks apart. While accesses are running, the gap between pass starts never exceeds TIMEOUT_CLKS + SETTLE_CLKS + 8.
- R9: During a data access, exactly one bank is powered and strobed, and it is the addressed bank.
- R10: While reset is held, ack, rd_data, bank_pwr, row_stb, col_stb and mem_we are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse marking the start of a machine cycle |
| req | input | 1 | CPU request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address {bank, row, column} |
| req_wdata | input | 4 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 4 | Read data, valid while ack is high |
| bank_pwr | output | 4 | Per-bank supply enable |
| row_stb | output | 4 | Per-bank row strobe, active high |
| col_stb | output | 4 | Per-bank column strobe, active high |
| mem_row | output | 5 | Row address to the devices |
| mem_col | output | 5 | Column address to the devices |
| mem_we | output | 1 | Device write enable, qualified by col_stb |
| mem_wdata | output | 4 | Data to the devices |
| mem_rdata | input | 4 | Data from the strobed devices |

## Verification
In an idle controller, a request driven before an edge is captured at that edge. For a populated bank, ack rises SETTLE_CLKS+3 edges later, after the captured request has passed through the serve cycle, the settle wait, and the row and column cycles. For an unpopulated bank, ack rises one edge after capture. The bench drives every input 1 ns after a falling edge and samples at the next falling edges. It counts those edges, so the latency checks land exactly on the cycle where ack is due. Exact-latency checks are made only right after a forced pass, when the timeout timer cannot intervene. Pass rows, settle windows and pass gaps are checked cycle by cycle by a monitor that counts falling edges from the first strobe of each pass.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;
   localparam int ADDR_W    = 12;
   localparam int DATA_W    = 4;
   localparam int ROW_W     = 5;
   localparam int COL_W     = 5;
   localparam int BSEL_W    = ADDR_W - ROW_W - COL_W;
   localparam int MAX_BANKS = 1 << BSEL_W;
   localparam int REF_HOLD  = 2;

   typedef enum logic [2:0] {
      S_IDLE, S_SETTLE, S_REF, S_ROW, S_COL, S_ACK
   } ctl_state_e;

   typedef struct packed {
      logic [BSEL_W-1:0] bank;
      logic [ROW_W-1:0]  row;
      logic [COL_W-1:0]  col;
      logic              we;
      logic [DATA_W-1:0] wd;
   } acc_t;

   function automatic acc_t split_req(input logic [ADDR_W-1:0] a,
                                      input logic we,
                                      input logic [DATA_W-1:0] wd);
      acc_t r;
      r.bank = a[ADDR_W-1 -: BSEL_W];
      r.row  = a[COL_W +: ROW_W];
      r.col  = a[COL_W-1:0];
      r.we   = we;
      r.wd   = wd;
      return r;
   endfunction
endpackage

// File: rtl/pgdram_settle.sv
module pgdram_settle #(
   parameter int CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(CLKS + 1);

   generate
      if (CLKS < 1) begin : g_bad
         $error("pgdram_settle: CLKS must be at least 1");
      end
      if (CLKS == 1) begin : g_direct
         logic unused_in;
         assign unused_in = ^{clk, rst_n, load, run};
         assign done      = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      cnt_q <= '0;
            else if (load)   cnt_q <= '0;
            else if (run && !done) cnt_q <= cnt_q + 1'b1;
         end
         assign done = (cnt_q == CW'(CLKS - 1));

         p_settle_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            run && !done && !load |=> cnt_q == $past(cnt_q) + 1'b1);
      end
   endgenerate
endmodule

// File: rtl/pgdram_refresh.sv
module pgdram_refresh #(
   parameter int ROW_W = 5,
   parameter int HOLD  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   output logic [ROW_W-1:0] row,
   output logic             last
);
   localparam int PW = (HOLD > 1) ? $clog2(HOLD) : 1;

   logic             ph_end;
   logic [ROW_W-1:0] row_q;

   generate
      if (HOLD < 1) begin : g_bad
         $error("pgdram_refresh: HOLD must be at least 1");
      end
      if (HOLD == 1) begin : g_single
         assign ph_end = 1'b1;
      end else begin : g_multi
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    ph_q <= '0;
            else if (load) ph_q <= '0;
            else if (run)  ph_q <= ph_end ? '0 : ph_q + 1'b1;
         end
         assign ph_end = (ph_q == PW'(HOLD - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                            row_q <= '0;
      else if (load)                         row_q <= '1;
      else if (run && ph_end && row_q != '0) row_q <= row_q - 1'b1;
   end

   assign row  = row_q;
   assign last = ph_end && (row_q == '0);

   p_row_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run && !load && ph_end && row_q != '0 |=> row_q == $past(row_q) - 1'b1);
   p_row_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> row_q == '1);
endmodule

// File: rtl/pgdram_timer.sv
module pgdram_timer #(
   parameter int LIMIT = 90000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 2) begin : g_bad
         $error("pgdram_timer: LIMIT must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (!expire) cnt_q <= cnt_q + 1'b1;
   end

   assign expire = (cnt_q == CW'(LIMIT - 1));

   p_timer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !clr |=> expire);
   p_timer_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !expire);
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
   import pgdram_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int SETTLE_CLKS  = 4,
   parameter int TIMEOUT_CLKS = 90000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cyc_start,
   input  logic                 req,
   input  logic                 req_we,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 ack,
   output logic [DATA_W-1:0]    rd_data,
   output logic [MAX_BANKS-1:0] bank_pwr,
   output logic [MAX_BANKS-1:0] row_stb,
   output logic [MAX_BANKS-1:0] col_stb,
   output logic [ROW_W-1:0]     mem_row,
   output logic [COL_W-1:0]     mem_col,
   output logic                 mem_we,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata
);
   localparam logic [MAX_BANKS-1:0] POP_MASK = MAX_BANKS'((1 << NUM_BANKS) - 1);
   localparam int OW = $clog2(SETTLE_CLKS + 1);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("pgdram_ctrl: NUM_BANKS out of range");
      end
      if (TIMEOUT_CLKS <= SETTLE_CLKS + REF_HOLD * (1 << ROW_W)) begin : g_bad_timeout
         $error("pgdram_ctrl: TIMEOUT_CLKS shorter than one pass");
      end
   endgenerate

   ctl_state_e           st_q;
   logic                 ref_mode_q, pend_q, swp_q, ack_q;
   acc_t                 acc_q;
   logic [MAX_BANKS-1:0] pwr_q;
   logic [DATA_W-1:0]    rd_q;

   logic settle_done, ref_last, expire;
   logic [ROW_W-1:0] ref_row;
   logic sweep_go, sweep_load, cap, bank_ok, in_ref, in_row, in_col;
   logic settle_load, ref_load;
   logic [MAX_BANKS-1:0] bank_sel;

   assign sweep_go   = swp_q | cyc_start | expire;
   assign sweep_load = (st_q == S_IDLE) && sweep_go;
   assign cap        = req && !pend_q && (st_q != S_ACK);
   assign bank_ok    = int'(acc_q.bank) < NUM_BANKS;
   assign bank_sel   = MAX_BANKS'(1) << acc_q.bank;
   assign settle_load = (st_q == S_IDLE) && (sweep_go || (pend_q && bank_ok));
   assign ref_load   = (st_q == S_SETTLE) && settle_done && ref_mode_q;
   assign in_ref     = (st_q == S_REF);
   assign in_row     = (st_q == S_ROW);
   assign in_col     = (st_q == S_COL);

   pgdram_settle #(.CLKS(SETTLE_CLKS)) u_settle (
      .clk (clk), .rst_n (rst_n), .load (settle_load),
      .run (st_q == S_SETTLE), .done (settle_done));

   pgdram_refresh #(.ROW_W(ROW_W), .HOLD(REF_HOLD)) u_refresh (
      .clk (clk), .rst_n (rst_n), .load (ref_load), .run (in_ref),
      .row (ref_row), .last (ref_last));

   pgdram_timer #(.LIMIT(TIMEOUT_CLKS)) u_timer (
      .clk (clk), .rst_n (rst_n), .clr (sweep_load), .expire (expire));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         ref_mode_q <= 1'b0;
         pend_q     <= 1'b0;
         swp_q      <= 1'b0;
         acc_q      <= '0;
         pwr_q      <= '0;
         ack_q      <= 1'b0;
         rd_q       <= '0;
      end else begin
         ack_q <= 1'b0;
         swp_q <= sweep_load ? 1'b0 : (swp_q | cyc_start | expire);
         if (cap) begin
            pend_q <= 1'b1;
            acc_q  <= split_req(req_addr, req_we, req_wdata);
         end
         unique case (st_q)
            S_IDLE: begin
               if (sweep_go) begin
                  st_q       <= S_SETTLE;
                  ref_mode_q <= 1'b1;
                  pwr_q      <= POP_MASK;
               end else if (pend_q) begin
                  if (!bank_ok) begin
                     st_q   <= S_ACK;
                     ack_q  <= 1'b1;
                     rd_q   <= '0;
                     pend_q <= 1'b0;
                  end else begin
                     st_q       <= S_SETTLE;
                     ref_mode_q <= 1'b0;
                     pwr_q      <= bank_sel;
                  end
               end
            end
            S_SETTLE: begin
               if (settle_done) st_q <= ref_mode_q ? S_REF : S_ROW;
            end
            S_REF: begin
               if (ref_last) begin
                  if (pend_q && !bank_ok) begin
                     st_q   <= S_ACK;
                     ack_q  <= 1'b1;
                     rd_q   <= '0;
                     pend_q <= 1'b0;
                     pwr_q  <= '0;
                  end else if (pend_q) begin
                     st_q  <= S_ROW;
                     pwr_q <= bank_sel;
                  end else begin
                     st_q  <= S_IDLE;
                     pwr_q <= '0;
                  end
               end
            end
            S_ROW: st_q <= S_COL;
            S_COL: begin
               st_q   <= S_ACK;
               ack_q  <= 1'b1;
               pend_q <= 1'b0;
               pwr_q  <= '0;
               rd_q   <= acc_q.we ? '0 : mem_rdata;
            end
            S_ACK: st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   genvar b;
   generate
      for (b = 0; b < MAX_BANKS; b++) begin : g_bank
         if (b < NUM_BANKS) begin : g_pop
            logic hit;
            logic [OW-1:0] on_q;
            assign hit        = (acc_q.bank == BSEL_W'(b));
            assign row_stb[b] = in_ref | ((in_row | in_col) & hit);
            assign col_stb[b] = in_col & hit;

            always_ff @(posedge clk) begin
               if (!rst_n)                 on_q <= '0;
               else if (!pwr_q[b])         on_q <= '0;
               else if (on_q != OW'(SETTLE_CLKS)) on_q <= on_q + 1'b1;
            end

            p_settle_before_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
               row_stb[b] |-> on_q == OW'(SETTLE_CLKS));
            p_stb_needs_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
               row_stb[b] |-> bank_pwr[b]);
         end else begin : g_unpop
            assign row_stb[b] = 1'b0;
            assign col_stb[b] = 1'b0;
            p_unpop_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
               !bank_pwr[b]);
         end
      end
   endgenerate

   assign bank_pwr  = pwr_q;
   assign ack       = ack_q;
   assign rd_data   = rd_q;
   assign mem_row   = in_ref ? ref_row : acc_q.row;
   assign mem_col   = in_col ? acc_q.col : '0;
   assign mem_we    = in_col & acc_q.we;
   assign mem_wdata = in_col ? acc_q.wd : '0;

   p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   p_col_with_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (col_stb & ~row_stb) == '0);
   p_data_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      col_stb != '0 |-> $onehot0(col_stb) && bank_pwr == col_stb);
   p_ref_no_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ref |-> col_stb == '0 && !mem_we && bank_pwr == POP_MASK);
   p_idle_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE || ack) |-> bank_pwr == '0);
   p_no_ack_in_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_ref |-> !ack && col_stb == '0);
endmodule

// File: tb/pgdram_ctrl_tb_top.sv
module pgdram_ctrl_tb_top;
   localparam int NB = 2;
   localparam int SC = 4;
   localparam int TO = 600;
   localparam logic [3:0] POP = 4'b0011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 1'b0, req = 1'b0, req_we = 1'b0;
   logic [11:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic ack, mem_we;
   logic [3:0] rd_data, bank_pwr, row_stb, col_stb, mem_wdata, mem_rdata;
   logic [4:0] mem_row, mem_col;

   always #10 clk = ~clk;

   pgdram_ctrl #(.NUM_BANKS(NB), .SETTLE_CLKS(SC), .TIMEOUT_CLKS(TO)) dut_i (
      .clk (clk), .rst_n (rst_n), .cyc_start (cyc_start), .req (req),
      .req_we (req_we), .req_addr (req_addr), .req_wdata (req_wdata),
      .ack (ack), .rd_data (rd_data), .bank_pwr (bank_pwr),
      .row_stb (row_stb), .col_stb (col_stb), .mem_row (mem_row),
      .mem_col (mem_col), .mem_we (mem_we), .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata));

   int n_chk = 0, n_fail = 0, cyc = 0;
   int sweeps = 0, k = 0, last_start = -1, sweep_end = 0, last_col = 0;
   int n_ops = 0, n_acks = 0;
   int on_cnt [4];
   bit in_sweep = 0, prev_ack = 0, quiet = 0, rnd_cs = 0, done_f = 0;
   logic [3:0] dev [0:4095];
   logic [3:0] ref_mem [0:4095];

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_rd(input logic [11:0] a);
      return (int'(a[11:10]) < NB) ? ref_mem[a] : 4'h0;
   endfunction

   // device model
   always @(posedge clk)
      if (mem_we)
         for (int b = 0; b < 4; b++)
            if (col_stb[b]) dev[b*1024 + int'(mem_row)*32 + int'(mem_col)] <= mem_wdata;

   always_comb begin
      mem_rdata = 4'h0;
      for (int b = 0; b < 4; b++)
         if (col_stb[b]) mem_rdata = dev[b*1024 + int'(mem_row)*32 + int'(mem_col)];
   end

   // cycle monitor
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         for (int b = 0; b < 4; b++) begin
            on_cnt[b] = bank_pwr[b] ? on_cnt[b] + 1 : 0;
            if (row_stb[b]) chk(on_cnt[b] >= SC + 1, "R3", "supply settle", on_cnt[b], SC + 1);
            if (b >= NB && (bank_pwr[b] | row_stb[b] | col_stb[b]))
               chk(0, "R2", "unpopulated bank activity", b, 0);
         end
         if (row_stb == POP && col_stb == 4'h0) begin
            if (!in_sweep) begin
               in_sweep = 1; k = 0;
               if (last_start >= 0) begin
                  if (quiet) chk(cyc - last_start == TO, "R8", "idle pass gap", cyc - last_start, TO);
                  else chk(cyc - last_start <= TO + SC + 8, "R8", "pass gap bound", cyc - last_start, TO + SC + 8);
               end
               last_start = cyc; sweeps++;
            end
            chk(mem_row == 5'(31 - k/2) && !mem_we && bank_pwr == POP, "R4", "pass row",
                mem_row, 31 - k/2);
            k++;
         end else if (in_sweep) begin
            in_sweep = 0; sweep_end = cyc;
            chk(k == 64, "R4", "pass strobe cycles", k, 64);
            if (!req) chk(bank_pwr == 4'h0, "R7", "supply after pass", bank_pwr, 0);
         end
         if (col_stb != 4'h0) begin
            chk($countones(col_stb) == 1 && row_stb == col_stb && bank_pwr == col_stb,
                "R9", "single bank access", {col_stb, bank_pwr}, {col_stb, col_stb});
            last_col = cyc;
         end
         if (ack) begin
            n_acks++;
            chk(!prev_ack, "R6", "ack width", 2, 1);
         end
         prev_ack = ack;
      end
   end

   task automatic op(input bit we, input logic [11:0] a, input logic [3:0] wd,
                     output logic [3:0] rd, output int lat);
      @(negedge clk); #1;
      req = 1'b1; req_we = we; req_addr = a; req_wdata = wd; lat = 0;
      do begin
         @(negedge clk); lat++;
      end while (!ack && lat < 2000);
      rd = rd_data;
      chk(bank_pwr == 4'h0, "R7", "supply at ack", bank_pwr, 0);
      #1 req = 1'b0;
      n_ops++;
      if (we && int'(a[11:10]) < NB) ref_mem[a] = wd;
   endtask

   task automatic pulse_cs();
      @(negedge clk); #1 cyc_start = 1'b1;
      @(negedge clk); #1 cyc_start = 1'b0;
   endtask

   task automatic wait_pass();
      int s0 = sweeps;
      while (sweeps == s0 || in_sweep) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) begin dev[i] = 4'h0; ref_mem[i] = 4'h0; end
      for (int b = 0; b < 4; b++) on_cnt[b] = 0;
   end

   // random machine-cycle starts
   initial begin
      forever begin
         @(negedge clk);
         if (rnd_cs) begin
            repeat ($urandom_range(80, 250)) @(negedge clk);
            if (rnd_cs) pulse_cs();
         end
      end
   end

   initial begin
      logic [3:0] rd;
      int lat;
      void'($urandom(32'h5EED_0C78));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(ack == 0 && rd_data == 0 && bank_pwr == 0 && row_stb == 0 && col_stb == 0 && mem_we == 0,
          "R10", "reset outputs", {ack, rd_data, bank_pwr, row_stb, col_stb}, 0);
      #1 rst_n = 1'b1;

      // R4 forced pass, then directed accesses with a fresh timer
      pulse_cs();
      wait_pass();
      op(1, 12'h000, 4'hA, rd, lat);
      chk(lat == SC + 4, "R6", "populated latency", lat, SC + 4);
      op(0, 12'h000, 4'h0, rd, lat);
      chk(rd == 4'hA, "R1", "read 0x000", rd, 4'hA);
      op(1, 12'h7FF, 4'h5, rd, lat);
      op(0, 12'h7FF, 4'h0, rd, lat);
      chk(rd == 4'h5, "R1", "read 0x7FF", rd, 4'h5);
      op(1, 12'h021, 4'h3, rd, lat);
      op(1, 12'h5A3, 4'hC, rd, lat);
      op(0, 12'h5A3, 4'h0, rd, lat);
      chk(rd == 4'hC, "R1", "read 0x5A3", rd, 4'hC);
      chk(dev[1*1024 + 5'h0D*32 + 5'h03] == 4'hC, "R1", "bank/row/col split", dev[1*1024 + 13*32 + 3], 4'hC);

      // R2 unpopulated bank
      op(1, 12'h821, 4'h9, rd, lat);
      chk(lat == 2 && rd == 4'h0, "R2", "unpopulated write ack", {lat[3:0], rd}, {4'h2, 4'h0});
      op(0, 12'h821, 4'h0, rd, lat);
      chk(rd == 4'h0, "R2", "unpopulated read", rd, 0);
      op(0, 12'h021, 4'h0, rd, lat);
      chk(rd == 4'h3, "R2", "alias untouched", rd, 4'h3);

      // R5 request during a pass
      pulse_cs();
      repeat (SC + 10) @(negedge clk);
      chk(in_sweep, "R5", "pass running", in_sweep, 1);
      op(0, 12'h7FF, 4'h0, rd, lat);
      chk(last_col > sweep_end - 1 && rd == 4'h5, "R5", "served after pass",
          last_col - sweep_end, 0);
      chk(last_col - sweep_end <= 2, "R5", "served right after pass", last_col - sweep_end, 1);

      // random traffic
      rnd_cs = 1;
      for (int i = 0; i < 160; i++) begin
         logic [11:0] a;
         logic [3:0] wd;
         bit we;
         a  = 12'($urandom);
         wd = 4'($urandom);
         we = 1'($urandom);
         if ($urandom % 6 == 0) a[9:5] = ($urandom % 2) ? 5'h1F : 5'h00;
         op(we, a, wd, rd, lat);
         if (!we) chk(rd == exp_rd(a), (int'(a[11:10]) < NB) ? "R1" : "R2", "random read", rd, exp_rd(a));
         repeat ($urandom_range(0, 10)) @(negedge clk);
      end
      rnd_cs = 0;

      // R8 idle timeout passes
      repeat (300) @(negedge clk);
      wait_pass();
      quiet = 1;
      wait_pass();
      wait_pass();
      quiet = 0;
      repeat (20) @(negedge clk);
      chk(n_acks == n_ops, "R6", "one ack per request", n_acks, n_ops);

      done_f = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_f) begin
         n_fail++;
         $display("FAIL watchdog R6: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule